// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Rights Check

This block turns a 32-bit virtual address into a physical address. It holds a small set of page table entries and searches all of them at once. Pages are 4 KB. The low 12 bits of the address pass through unchanged. The upper 20 bits form the page number, which is compared against every stored tag in parallel.

Each entry stores:
- a page tag
- a frame number
- a valid flag
- a referenced flag
- a modified (dirty) flag
- a two-bit rights code

Every request is answered one clock later with exactly one of three outcomes: a hit with a physical address, a miss, or a protection fault. A hit also returns the entry's referenced and modified flags as they stood before the access.

A page table walker outside the block loads entries through a fill port. The fill target is chosen in this order:
1. an entry already holding the same page;
2. otherwise the lowest-numbered empty entry;
3. otherwise the entry named by a rotating victim pointer.

A flush input empties the whole buffer in one cycle.

Top module: `tlb_xlate`

## Requirements
- R1: On a hit, `rsp_paddr` equals the entry's 20-bit frame number followed by bits 11:0 of the request address.
- R2: Results appear on the second rising edge after the request. `rsp_valid` is high one cycle after `req_valid` and low otherwise. While `rsp_valid` is high, exactly one of `rsp_hit`, `rsp_miss`, `rsp_fault` is set. While it is low, all three are low.
- R3: Rights codes are 00 read-only, 01 read/write, 10 execute-only and 11 no access. Access kinds are 00 load, 01 store, 10 instruction fetch and 11 reserved. The allowed pairs are load under 00, load or store under 01, and fetch under 10. A matching valid entry with any other pair gives `rsp_fault` with `rsp_paddr` zero.
- R4: A request whose page matches no valid entry gives `rsp_miss` with `rsp_paddr` zero.
- R5: A hit reports in `rsp_ref` the entry's referenced flag before the access, then sets that flag. Faults and misses leave it unchanged.
- R6: A store hit reports in `rsp_dirty` the entry's modified flag before the access, then sets that flag. Load and fetch hits and faults leave it unchanged.
- R7: A fill stores the tag, frame number and rights, marks the entry valid, and clears its referenced and modified flags. The target is chosen as follows:
  - an entry already valid for the same page is overwritten;
  - otherwise the lowest-numbered invalid entry is used;
  - otherwise the entry at the victim pointer is used. The pointer starts at 0 after reset and advances by one, modulo 8, only when it is used.
- R8: `flush` clears every valid flag on one edge. A fill in the same cycle is discarded.
- R9: A lookup in the same cycle as a fill or flush sees the contents from before that cycle's edge.
- R10: At most one valid entry matches a given page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind (00 load, 01 store, 10 fetch, 11 reserved) |
| flush | input | 1 | Invalidate all entries |
| fill_en | input | 1 | Write one entry |
| fill_vpn | input | 20 | Page tag for the fill |
| fill_pfn | input | 20 | Frame number for the fill |
| fill_rights | input | 2 | Rights code for the fill |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation delivered |
| rsp_miss | output | 1 | No valid matching entry |
| rsp_fault | output | 1 | Access kind not permitted by the rights |
| rsp_paddr | output | 32 | Physical address, zero unless hit |
| rsp_ref | output | 1 | Referenced flag before this hit |
| rsp_dirty | output | 1 | Modified flag before this hit |

## Verification
The hardest state to reach from the ports is the victim pointer. It only matters once all eight entries are valid, and its value can only be read indirectly, by seeing which translation turns into a miss.

The stimulus flushes the buffer and fills eight distinct pages into the empty slots in index order. It then adds new pages one at a time and probes the neighbouring pages after each addition. A fill that repeats a page already present is placed between two replacements. This shows that a repeated page overwrites its own slot and does not move the pointer.

The flags are observed through `rsp_ref` and `rsp_dirty`, by repeating lookups on the same page. Lookups are also issued in the same cycle as a fill and as a flush, to show which contents each one sees.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   typedef enum logic [1:0] {
      RGT_RDONLY = 2'b00,
      RGT_RDWR   = 2'b01,
      RGT_EXONLY = 2'b10,
      RGT_NONE   = 2'b11
   } rights_e;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'b00,
      ACC_STORE = 2'b01,
      ACC_FETCH = 2'b10,
      ACC_RSVD  = 2'b11
   } acc_e;
endpackage

// File: rtl/tlb_rights_chk.sv
module tlb_rights_chk
   import tlb_pkg::*;
(
   input  logic [1:0] rights,
   input  logic [1:0] kind,
   output logic       allow
);
   always_comb begin
      unique case (rights)
         RGT_RDONLY: allow = (kind == ACC_LOAD);
         RGT_RDWR:   allow = (kind == ACC_LOAD) || (kind == ACC_STORE);
         RGT_EXONLY: allow = (kind == ACC_FETCH);
         default:    allow = 1'b0;
      endcase
   end
endmodule

// File: rtl/tlb_fill_sel.sv
module tlb_fill_sel #(
   parameter int ENTRIES = 8,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fill_go,
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic [ENTRIES-1:0] dup_vec,
   output logic [IDX_W-1:0]   fill_idx
);
   logic [IDX_W-1:0] ptr_q;
   logic [IDX_W-1:0] free_idx;
   logic [IDX_W-1:0] dup_idx;
   logic             free_found;
   logic             any_dup;
   logic             use_ptr;

   always_comb begin
      free_found = 1'b0;
      free_idx   = '0;
      dup_idx    = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (!valid_vec[e]) begin
            free_found = 1'b1;
            free_idx   = IDX_W'(e);
         end
         if (dup_vec[e]) dup_idx = IDX_W'(e);
      end
      any_dup  = |dup_vec;
      use_ptr  = fill_go && !any_dup && !free_found;
      fill_idx = any_dup ? dup_idx : (free_found ? free_idx : ptr_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (use_ptr) begin
         ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
      end
   end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
   import tlb_pkg::*;
#(
   parameter int VA_W     = 32,
   parameter int PA_W     = 32,
   parameter int PG_OFS_W = 12,
   parameter int ENTRIES  = 8,
   localparam int VPN_W   = VA_W - PG_OFS_W,
   localparam int PFN_W   = PA_W - PG_OFS_W,
   localparam int IDX_W   = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic [1:0]       req_kind,
   input  logic             flush,
   input  logic             fill_en,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PFN_W-1:0] fill_pfn,
   input  logic [1:0]       fill_rights,
   output logic             rsp_valid,
   output logic             rsp_hit,
   output logic             rsp_miss,
   output logic             rsp_fault,
   output logic [PA_W-1:0]  rsp_paddr,
   output logic             rsp_ref,
   output logic             rsp_dirty
);
   if (ENTRIES < 2) begin : g_bad_entries
      $error("tlb_xlate: ENTRIES must be at least 2");
   end
   if (VA_W <= PG_OFS_W) begin : g_bad_va
      $error("tlb_xlate: VA_W must exceed PG_OFS_W");
   end
   if (PA_W <= PG_OFS_W) begin : g_bad_pa
      $error("tlb_xlate: PA_W must exceed PG_OFS_W");
   end

   logic [VPN_W-1:0] tag_q [ENTRIES];
   logic [PFN_W-1:0] pfn_q [ENTRIES];
   logic [1:0]       rgt_q [ENTRIES];
   logic [ENTRIES-1:0] vld_q, ref_q, dty_q;

   logic [VPN_W-1:0]   req_vpn;
   logic [ENTRIES-1:0] hit_vec;
   logic [ENTRIES-1:0] dup_vec;
   logic [PFN_W-1:0]   sel_pfn;
   logic [1:0]         sel_rgt;
   logic               sel_ref, sel_dty;
   logic               allow;
   logic               lk_hit, lk_miss, lk_fault;
   logic               fill_go;
   logic               is_store;
   logic [IDX_W-1:0]   fill_idx;

   assign req_vpn  = req_vaddr[VA_W-1:PG_OFS_W];
   assign fill_go  = fill_en && !flush;
   assign is_store = (req_kind == ACC_STORE);

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = vld_q[g] && (tag_q[g] == req_vpn);
      assign dup_vec[g] = vld_q[g] && (tag_q[g] == fill_vpn);
   end

   always_comb begin
      sel_pfn = '0;
      sel_rgt = '0;
      sel_ref = 1'b0;
      sel_dty = 1'b0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (hit_vec[e]) begin
            sel_pfn |= pfn_q[e];
            sel_rgt |= rgt_q[e];
            sel_ref |= ref_q[e];
            sel_dty |= dty_q[e];
         end
      end
   end

   tlb_rights_chk u_rights (
      .rights (sel_rgt),
      .kind   (req_kind),
      .allow  (allow)
   );

   assign lk_hit   = req_valid && (|hit_vec) && allow;
   assign lk_fault = req_valid && (|hit_vec) && !allow;
   assign lk_miss  = req_valid && !(|hit_vec);

   tlb_fill_sel #(.ENTRIES(ENTRIES)) u_fill_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .fill_go   (fill_go),
      .valid_vec (vld_q),
      .dup_vec   (dup_vec),
      .fill_idx  (fill_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         ref_q <= '0;
         dty_q <= '0;
         for (int e = 0; e < ENTRIES; e++) begin
            tag_q[e] <= '0;
            pfn_q[e] <= '0;
            rgt_q[e] <= RGT_NONE;
         end
      end else begin
         for (int e = 0; e < ENTRIES; e++) begin
            if (flush) begin
               vld_q[e] <= 1'b0;
            end else if (fill_go && (fill_idx == IDX_W'(e))) begin
               tag_q[e] <= fill_vpn;
               pfn_q[e] <= fill_pfn;
               rgt_q[e] <= fill_rights;
               vld_q[e] <= 1'b1;
               ref_q[e] <= 1'b0;
               dty_q[e] <= 1'b0;
            end else if (lk_hit && hit_vec[e]) begin
               ref_q[e] <= 1'b1;
               if (is_store) dty_q[e] <= 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_miss  <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_paddr <= '0;
         rsp_ref   <= 1'b0;
         rsp_dirty <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         rsp_hit   <= lk_hit;
         rsp_miss  <= lk_miss;
         rsp_fault <= lk_fault;
         rsp_paddr <= lk_hit ? {sel_pfn, req_vaddr[PG_OFS_W-1:0]} : '0;
         rsp_ref   <= lk_hit && sel_ref;
         rsp_dirty <= lk_hit && sel_dty;
      end
   end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
   parameter int VA_W     = 32,
   parameter int PA_W     = 32,
   parameter int PG_OFS_W = 12,
   parameter int ENTRIES  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic [VA_W-1:0]    req_vaddr,
   input logic               flush,
   input logic [ENTRIES-1:0] hit_vec,
   input logic               rsp_valid,
   input logic               rsp_hit,
   input logic               rsp_miss,
   input logic               rsp_fault,
   input logic [PA_W-1:0]    rsp_paddr
);
   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R2
   AST_RSP_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R2
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1)); // R2
   AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault)); // R2
   AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> (rsp_paddr[PG_OFS_W-1:0] == $past(req_vaddr[PG_OFS_W-1:0]))); // R1
   AST_NO_ADDR_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (rsp_paddr == '0)); // R3
   AST_NO_ADDR_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_miss |-> (rsp_paddr == '0)); // R4
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flush, 2) && $past(req_valid)) |-> rsp_miss); // R8
   AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec)); // R10
endmodule

bind tlb_xlate tlb_xlate_chk #(
   .VA_W(VA_W), .PA_W(PA_W), .PG_OFS_W(PG_OFS_W), .ENTRIES(ENTRIES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
   .flush(flush), .hit_vec(hit_vec), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
   .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
);

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_kind = '0;
   logic        flush = 1'b0;
   logic        fill_en = 1'b0;
   logic [19:0] fill_vpn = '0;
   logic [19:0] fill_pfn = '0;
   logic [1:0]  fill_rights = '0;
   logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_ref, rsp_dirty;
   logic [31:0] rsp_paddr;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tlb_xlate u_tlb_xlate (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_kind(req_kind), .flush(flush), .fill_en(fill_en), .fill_vpn(fill_vpn),
      .fill_pfn(fill_pfn), .fill_rights(fill_rights), .rsp_valid(rsp_valid),
      .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
      .rsp_paddr(rsp_paddr), .rsp_ref(rsp_ref), .rsp_dirty(rsp_dirty)
   );

   localparam logic [1:0] LD = 2'd0, ST = 2'd1, FE = 2'd2, RS = 2'd3;
   localparam logic [1:0] HIT = 2'd1, MISS = 2'd2, FLT = 2'd3;

   typedef struct packed {
      logic [31:0] va;
      logic [1:0]  kind;
      logic [1:0]  res;
      logic [31:0] pa;
      logic        r;
      logic        d;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VEC [NV] = '{
      '{32'h0001_0123, LD, HIT,  32'h0A00_0123, 1'b0, 1'b0},
      '{32'h0001_0123, LD, HIT,  32'h0A00_0123, 1'b1, 1'b0},
      '{32'h0001_0FFF, ST, FLT,  32'h0,         1'b0, 1'b0},
      '{32'h0001_0000, FE, FLT,  32'h0,         1'b0, 1'b0},
      '{32'h0001_0010, LD, HIT,  32'h0A00_0010, 1'b1, 1'b0},
      '{32'h0002_0456, ST, HIT,  32'h0B00_0456, 1'b0, 1'b0},
      '{32'h0002_0457, LD, HIT,  32'h0B00_0457, 1'b1, 1'b1},
      '{32'h0002_0000, FE, FLT,  32'h0,         1'b0, 1'b0},
      '{32'h0003_0ABC, LD, FLT,  32'h0,         1'b0, 1'b0},
      '{32'h0003_0ABC, FE, HIT,  32'h0C00_0ABC, 1'b0, 1'b0},
      '{32'h0004_0001, LD, FLT,  32'h0,         1'b0, 1'b0},
      '{32'h0004_0001, ST, FLT,  32'h0,         1'b0, 1'b0},
      '{32'h0005_0000, LD, MISS, 32'h0,         1'b0, 1'b0},
      '{32'hFFFF_FFFF, ST, MISS, 32'h0,         1'b0, 1'b0},
      '{32'h0002_0000, RS, FLT,  32'h0,         1'b0, 1'b0}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] outcome();
      if (rsp_fault) return FLT;
      if (rsp_miss)  return MISS;
      if (rsp_hit)   return HIT;
      return 2'd0;
   endfunction

   task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [1:0] rgt);
      @(negedge clk);
      fill_en = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_rights = rgt;
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic lookup(input logic [31:0] va, input logic [1:0] k, input logic [1:0] res,
                         input logic [31:0] pa, input logic r, input logic d, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_kind = k;
      @(negedge clk);
      req_valid = 1'b0;
      check({"R2 valid ", tag}, 32'(rsp_valid), 32'd1);
      check({tag, " outcome"}, 32'(outcome()), 32'(res));
      if (res == HIT) begin
         check({"R1 paddr ", tag}, rsp_paddr, pa);
         check({"R5 ref ", tag}, 32'(rsp_ref), 32'(r));
         check({"R6 dirty ", tag}, 32'(rsp_dirty), 32'(d));
      end else begin
         check({"R4 paddr zero ", tag}, rsp_paddr, 32'h0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL R2 watchdog act=running exp=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      check("R2 reset valid", 32'(rsp_valid), 32'd0);
      check("R2 reset outcome", 32'(outcome()), 32'd0);
      rst_n = 1'b1;
      lookup(32'h0001_0000, LD, MISS, 0, 0, 0, "R4 empty after reset");

      fill(20'h00010, 20'h0A000, 2'b00);
      fill(20'h00020, 20'h0B000, 2'b01);
      fill(20'h00030, 20'h0C000, 2'b10);
      fill(20'h00040, 20'h0D000, 2'b11);
      for (int i = 0; i < NV; i++) begin
         lookup(VEC[i].va, VEC[i].kind, VEC[i].res, VEC[i].pa, VEC[i].r, VEC[i].d,
                (VEC[i].res == FLT) ? "R3 vec" : (VEC[i].res == MISS) ? "R4 vec" : "R1 vec");
      end

      @(negedge clk);
      check("R2 idle no response", 32'(rsp_valid), 32'd0);

      // R9: lookup in the same cycle as a fill sees the old contents
      @(negedge clk);
      fill_en = 1'b1; fill_vpn = 20'h00060; fill_pfn = 20'h0E000; fill_rights = 2'b01;
      req_valid = 1'b1; req_vaddr = 32'h0006_0008; req_kind = LD;
      @(negedge clk);
      fill_en = 1'b0; req_valid = 1'b0;
      check("R9 lookup during fill", 32'(outcome()), 32'(MISS));
      lookup(32'h0006_0008, LD, HIT, 32'h0E00_0008, 0, 0, "R7 after fill");

      // R9: lookup in the flush cycle sees the old contents
      @(negedge clk);
      flush = 1'b1; req_valid = 1'b1; req_vaddr = 32'h0001_0004; req_kind = LD;
      @(negedge clk);
      flush = 1'b0; req_valid = 1'b0;
      check("R9 lookup during flush", 32'(outcome()), 32'(HIT));
      check("R9 paddr during flush", rsp_paddr, 32'h0A00_0004);
      lookup(32'h0001_0004, LD, MISS, 0, 0, 0, "R8 after flush");
      lookup(32'h0006_0000, LD, MISS, 0, 0, 0, "R8 after flush b");

      // R8: flush beats a fill in the same cycle
      @(negedge clk);
      flush = 1'b1; fill_en = 1'b1; fill_vpn = 20'h00070; fill_pfn = 20'h0F000; fill_rights = 2'b01;
      @(negedge clk);
      flush = 1'b0; fill_en = 1'b0;
      lookup(32'h0007_0000, LD, MISS, 0, 0, 0, "R8 fill dropped");

      // R7: fill order and round-robin replacement
      for (int i = 0; i < 8; i++) fill(20'h00100 + 20'(i), 20'h00200 + 20'(i), 2'b01);
      fill(20'h00108, 20'h00208, 2'b01);
      lookup(32'h0010_0000, LD, MISS, 0, 0, 0, "R7 slot0 replaced");
      lookup(32'h0010_1000, LD, HIT, 32'h0020_1000, 0, 0, "R7 slot1 kept");
      lookup(32'h0010_8123, LD, HIT, 32'h0020_8123, 0, 0, "R7 new page");
      fill(20'h00109, 20'h00209, 2'b01);
      lookup(32'h0010_1000, LD, MISS, 0, 0, 0, "R7 slot1 replaced");
      lookup(32'h0010_2000, ST, HIT, 32'h0020_2000, 0, 0, "R7 slot2 kept");
      fill(20'h00102, 20'h33333, 2'b01);
      lookup(32'h0010_2ABC, LD, HIT, 32'h3333_3ABC, 0, 0, "R7 overwrite clears flags");
      fill(20'h0010A, 20'h0020A, 2'b01);
      lookup(32'h0010_2000, LD, MISS, 0, 0, 0, "R7 pointer at slot2");
      lookup(32'h0010_3000, LD, HIT, 32'h0020_3000, 0, 0, "R7 slot3 kept");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule